// File: doc/BRIEF.md
# Tower-Field AES Byte Substitution Unit

This block substitutes one byte through the AES S-box or through its inverse, chosen by a single direction input. It holds no lookup table. It finds the multiplicative inverse in GF(2^8) by rewriting the byte in the composite field GF((2^4)^2), inverting it there, and mapping the result back. One inverter serves both directions. The forward affine step follows the inverter. The inverse affine step comes before it.

The unit is purely combinational: the output follows `byte_in` and `inverse` with no clock. A cipher datapath places it in its round logic. Only one direction is needed at a time, so a mux at each side of the shared inverter steers the byte. The basis-change matrices are derived when the design elaborates, from the tower polynomials: x^4+x+1 over GF(2), and y^2+y+λ over GF(2^4) with λ = w^3+w^2.

Top module: `aes_sbox_tower`

## Requirements
- R1: With `inverse`=0, `byte_out` is the AES S-box value of `byte_in`. Take v, the GF(2^8) inverse of the input under polynomial 0x11B, with 0 mapped to 0. Then `byte_out` is v ^ rotl(v,1) ^ rotl(v,2) ^ rotl(v,3) ^ rotl(v,4) ^ 0x63. For example, 0x01 gives 0x7C and 0x53 gives 0xED.
- R2: With `inverse`=1, `byte_out` is the unique byte x whose forward substitution under R1 equals `byte_in`.
- R3: `inverse` set to 0 selects the forward direction and 1 selects the inverse direction. The direction may change on every input change with no effect on the next result.
- R4: The forward substitution of 0x00 is 0x63.
- R5: The inverse substitution of 0x63 is 0x00.
- R6: For every byte x, the inverse substitution of the forward substitution of x returns x.
- R7: In both directions, `byte_out` never equals `byte_in` and never equals the bitwise complement of `byte_in`.
- R8: Take the inverter input and output in the polynomial basis. Their GF(2^8) product under 0x11B is 0x01 for every nonzero input, and the output is 0x00 when the input is 0x00.
- R9: The output is a combinational function of the present inputs: a new input gives its result within the same clock period, with no clock or register involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| byte_in | input | 8 | Byte to substitute |
| inverse | input | 1 | 0: forward S-box, 1: inverse S-box |
| byte_out | output | 8 | Substituted byte |

## Verification
Every one of the 256 bytes is sent through the forward direction and then through the inverse direction, and each result is compared with tables the bench builds by brute-force field inversion. This catches wrong basis-change constants, which would corrupt most bytes in either direction. A second sweep feeds each forward result back through the inverse direction. This exposes an inverse affine step that does not match the forward one, even when the forward table is correct. An interleaved pattern switches direction on every input and separates a correct direction mux from one that is swapped or stuck. The two zero-related bytes, 0x00 forward and 0x63 inverse, are driven on their own because the inverter's zero case bypasses the normal field inverse.

// File: rtl/aes_sbox_tower.sv
module aes_sbox_tower (
  input  logic [7:0] byte_in,
  input  logic       inverse,
  output logic [7:0] byte_out
);

  function automatic logic [7:0] g8_mul(logic [7:0] a, logic [7:0] b);
    logic [7:0] r, x;
    r = 8'h00;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r = r ^ x;
      x = x[7] ? ({x[6:0], 1'b0} ^ 8'h1b) : {x[6:0], 1'b0};
    end
    return r;
  endfunction

  function automatic logic [7:0] mat_apply(logic [63:0] m, logic [7:0] x);
    logic [7:0] r;
    r = 8'h00;
    for (int k = 0; k < 8; k++)
      if (x[k]) r = r ^ m[8*k +: 8];
    return r;
  endfunction

  function automatic logic [63:0] build_from_tower();
    logic [7:0]  w, y, lam;
    logic [63:0] m;
    logic        fw, fy;
    w = 8'h00; y = 8'h00; fw = 1'b0; fy = 1'b0; m = '0;
    for (int a = 2; a < 256; a++)
      if (!fw && ((g8_mul(g8_mul(8'(a), 8'(a)), g8_mul(8'(a), 8'(a))) ^ 8'(a) ^ 8'h01) == 8'h00)) begin
        w  = 8'(a);
        fw = 1'b1;
      end
    m[7:0] = 8'h01;
    for (int k = 1; k < 4; k++)
      m[8*k +: 8] = g8_mul(m[8*(k-1) +: 8], w);
    lam = m[31:24] ^ m[23:16];
    for (int a = 0; a < 256; a++)
      if (!fy && ((g8_mul(8'(a), 8'(a)) ^ 8'(a) ^ lam) == 8'h00)) begin
        y  = 8'(a);
        fy = 1'b1;
      end
    for (int k = 0; k < 4; k++)
      m[8*(k+4) +: 8] = g8_mul(y, m[8*k +: 8]);
    return m;
  endfunction

  function automatic logic [63:0] invert_map(logic [63:0] from_m);
    logic [63:0] to_m;
    to_m = '0;
    for (int j = 0; j < 8; j++)
      for (int a = 0; a < 256; a++)
        if (mat_apply(from_m, 8'(a)) == (8'h01 << j))
          to_m[8*j +: 8] = 8'(a);
    return to_m;
  endfunction

  localparam logic [63:0] FROM_TW = build_from_tower();
  localparam logic [63:0] TO_TW   = invert_map(FROM_TW);
  localparam logic [3:0]  LAMBDA  = 4'hC;

  function automatic logic [3:0] g16_mul(logic [3:0] a, logic [3:0] b);
    logic [3:0] r, x;
    r = 4'h0;
    x = a;
    for (int i = 0; i < 4; i++) begin
      if (b[i]) r = r ^ x;
      x = x[3] ? ({x[2:0], 1'b0} ^ 4'h3) : {x[2:0], 1'b0};
    end
    return r;
  endfunction

  function automatic logic [3:0] g16_sq(logic [3:0] a);
    return {a[3], a[1] ^ a[3], a[2], a[0] ^ a[2]};
  endfunction

  function automatic logic [3:0] g16_scale(logic [3:0] a);
    return g16_mul(a, LAMBDA);
  endfunction

  function automatic logic [3:0] g16_inv(logic [3:0] a);
    logic [3:0] a2, a4, a8;
    a2 = g16_sq(a);
    a4 = g16_sq(a2);
    a8 = g16_sq(a4);
    return g16_mul(g16_mul(a8, a4), a2);
  endfunction

  function automatic logic [7:0] rotl(logic [7:0] x, int n);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[(i + n) % 8] = x[i];
    return r;
  endfunction

  function automatic logic [7:0] fwd_affine(logic [7:0] v);
    return v ^ rotl(v, 1) ^ rotl(v, 2) ^ rotl(v, 3) ^ rotl(v, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] inv_affine(logic [7:0] v);
    logic [7:0] u;
    u = v ^ 8'h63;
    return rotl(u, 1) ^ rotl(u, 3) ^ rotl(u, 6);
  endfunction

  logic [7:0] pre, tw, inv8;
  logic [3:0] hi, lo, nrm, nrm_inv, oh, ol;

  assign pre      = inverse ? inv_affine(byte_in) : byte_in;
  assign tw       = mat_apply(TO_TW, pre);
  assign hi       = tw[7:4];
  assign lo       = tw[3:0];
  assign nrm      = g16_scale(g16_sq(hi)) ^ g16_mul(hi, lo) ^ g16_sq(lo);
  assign nrm_inv  = g16_inv(nrm);
  assign oh       = g16_mul(hi, nrm_inv);
  assign ol       = g16_mul(hi ^ lo, nrm_inv);
  assign inv8     = mat_apply(FROM_TW, {oh, ol});
  assign byte_out = inverse ? inv8 : fwd_affine(inv8);

endmodule

module aes_sbox_tower_chk (
  input logic [7:0] byte_in,
  input logic       inverse,
  input logic [7:0] byte_out,
  input logic [7:0] field_in,
  input logic [7:0] field_out
);

  function automatic logic [7:0] pmul(logic [7:0] a, logic [7:0] b);
    logic [7:0] r, x;
    r = 8'h00;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r = r ^ x;
      x = x[7] ? ({x[6:0], 1'b0} ^ 8'h1b) : {x[6:0], 1'b0};
    end
    return r;
  endfunction

  always_comb begin
    // R4
    fwd_zero_chk: assert (!(inverse == 1'b0 && byte_in == 8'h00) || byte_out == 8'h63)
      else $error("forward zero mapping wrong");
    // R5
    inv_zero_chk: assert (!(inverse == 1'b1 && byte_in == 8'h63) || byte_out == 8'h00)
      else $error("inverse of 0x63 wrong");
    // R7
    no_fixed_chk: assert (byte_out != byte_in)
      else $error("fixed point seen");
    // R7
    no_cofixed_chk: assert (byte_out != ~byte_in)
      else $error("opposite fixed point seen");
    // R8
    field_inv_chk: assert (field_in == 8'h00 || pmul(field_in, field_out) == 8'h01)
      else $error("field inverse product not one");
    // R8
    field_zero_chk: assert (field_in != 8'h00 || field_out == 8'h00)
      else $error("zero not mapped to zero");
  end

endmodule

bind aes_sbox_tower aes_sbox_tower_chk u_chk (
  .byte_in  (byte_in),
  .inverse  (inverse),
  .byte_out (byte_out),
  .field_in (pre),
  .field_out(inv8)
);

// File: tb/test_aes_sbox_tower.sv
module test_aes_sbox_tower;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [7:0] byte_in = 8'h00;
  logic       inverse = 1'b0;
  logic [7:0] byte_out;

  aes_sbox_tower i_aes_sbox_tower (
    .byte_in (byte_in),
    .inverse (inverse),
    .byte_out(byte_out)
  );

  typedef struct packed {
    logic [3:0] req;
    logic [7:0] din;
    logic [7:0] exp;
  } item_t;

  item_t      sb[$];
  int         errors = 0;
  int         checks = 0;
  logic       done = 1'b0;
  logic [7:0] fwd_tab [256];
  logic [7:0] inv_tab [256];

  function automatic logic [7:0] fmul(logic [7:0] a, logic [7:0] b);
    logic [15:0] p;
    p = 16'h0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
    for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h011b << (i - 8));
    return p[7:0];
  endfunction

  function automatic logic [7:0] affine(logic [7:0] v);
    logic [7:0] b;
    for (int i = 0; i < 8; i++)
      b[i] = v[i] ^ v[(i+4)%8] ^ v[(i+5)%8] ^ v[(i+6)%8] ^ v[(i+7)%8];
    return b ^ 8'h63;
  endfunction

  task automatic build_tables();
    for (int x = 0; x < 256; x++) begin
      logic [7:0] v;
      v = 8'h00;
      for (int y = 1; y < 256; y++)
        if (fmul(8'(x), 8'(y)) == 8'h01) v = 8'(y);
      fwd_tab[x] = affine(v);
    end
    for (int x = 0; x < 256; x++) inv_tab[fwd_tab[x]] = 8'(x);
  endtask

  // R9: input applied just after an edge, result sampled half a period later
  task automatic drive(input logic dir, input logic [7:0] d, input logic [7:0] e, input logic [3:0] r);
    @(posedge clk);
    #1;
    inverse = dir;
    byte_in = d;
    sb.push_back({r, d, e});
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() != 0) begin
        item_t it;
        it = sb.pop_front();
        checks++;
        if (byte_out !== it.exp) begin
          errors++;
          $display("FAIL R%0d dir=%0b in=%02h actual=%02h expected=%02h",
                   it.req, inverse, it.din, byte_out, it.exp);
        end
        checks++;
        if (byte_out === it.din || byte_out === ~it.din) begin
          errors++;
          $display("FAIL R7 in=%02h actual=%02h expected neither %02h nor %02h",
                   it.din, byte_out, it.din, ~it.din);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    build_tables();
    drive(1'b0, 8'h00, 8'h63, 4'd4);  // R4
    drive(1'b1, 8'h63, 8'h00, 4'd5);  // R5
    drive(1'b0, 8'h01, 8'h7c, 4'd1);  // R1 known value
    drive(1'b0, 8'h53, 8'hed, 4'd1);  // R1 known value
    for (int x = 0; x < 256; x++) drive(1'b0, 8'(x), fwd_tab[x], 4'd1);  // R1
    for (int x = 0; x < 256; x++) drive(1'b1, 8'(x), inv_tab[x], 4'd2);  // R2
    for (int x = 0; x < 256; x++) drive(1'b1, fwd_tab[x], 8'(x), 4'd6);  // R6
    for (int x = 0; x < 256; x += 7) begin  // R3 direction toggles every input
      drive(1'b0, 8'(x), fwd_tab[x], 4'd3);
      drive(1'b1, 8'(x), inv_tab[x], 4'd3);
    end
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule